// File: doc/BRIEF.md
# Far-End Loopback Command Decoder

This block sits behind the far-end alarm and control channel of a DS3 demultiplexer. Upstream logic extracts 6-bit codewords from the line and qualifies them. Each qualified codeword reaches this block as a value with a one-cycle accept strobe. The decoder keeps loopback status for the DS3 and for each of its 28 DS1 tributaries.

Loopback control is a two-step exchange. First an activate or a deactivate command arrives, and the decoder stores it. Then a target indication arrives, and the decoder applies the stored command to that target. The target is the DS3, all DS1s at once, or one DS1 channel. After each step that carries meaning, the decoder keeps the codeword in a status register and raises a sticky interrupt. Software clears the interrupt with a write-one-to-clear strobe.

All outputs are registered. Each one changes on the rising clock edge that samples the accept strobe.

Top module: `feac_lpbk_decoder`

## Requirements
- R1: On an accepted codeword that is a command or an indication, `code_o` takes that codeword on the sampling edge. The command codes are activate 000111 and deactivate 011100. The indication codes are 010011 (all DS1), 011011 (DS3), and 100001 through 111100 (single DS1).
- R2: An accepted command or indication sets `irq_o` to 1. The bit stays at 1 until a cycle with `irq_clr_i` high and no new recognised codeword. When a set and a clear arrive in the same cycle, the set wins.
- R3: An accepted activate or deactivate is stored as the pending command. A later command replaces the stored one. A command alone changes no loopback bit.
- R4: A pending activate followed by the DS3 indication 011011 sets `ds3_lb_o`. A pending deactivate followed by the same indication clears it.
- R5: A pending activate followed by the all-DS1 indication 010011 sets all 28 bits of `ds1_lb_o`. A pending deactivate followed by the same indication clears all of them.
- R6: A pending command followed by a single-channel code sets or clears bit (code − 33) of `ds1_lb_o`. Code 100001 selects bit 0 and 111100 selects bit 27. No other bit changes.
- R7: Any indication clears the pending command. An indication that arrives with no pending command updates `code_o` and `irq_o` but changes no loopback bit.
- R8: An accepted codeword that is neither a command nor an indication (for example 000000, 100000 or 111101) changes nothing. `code_o`, `irq_o`, the pending command and the loopback bits all keep their values.
- R9: A synchronous active-high reset sets `code_o` to 0 and clears `irq_o`, all loopback bits and the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 6 | Accepted codeword |
| code_vld_i | input | 1 | Accept strobe for `code_i` |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt |
| code_o | output | 6 | Last recognised codeword |
| irq_o | output | 1 | Sticky loopback interrupt |
| ds3_lb_o | output | 1 | DS3 loopback detected |
| ds1_lb_o | output | 28 | Per-DS1 loopback detected, bit n = channel code 33+n |

## Verification
The assertions check on every cycle the following:
- a recognised codeword loads into `code_o` and sets the interrupt;
- the interrupt holds until it is cleared;
- a foreign codeword or an idle cycle leaves the loopback bits still;
- a pending command is dropped after an indication;
- a single-channel code moves at most one DS1 bit;
- a pending activate followed by the DS3 indication sets the DS3 bit.

Only the bench scenarios can show the rest:
- a command replacing an earlier command;
- the exact bit chosen at the edges of the channel range;
- an indication with no pending command being inert;
- the whole two-step sequence for each target in both directions.

// File: rtl/feac_lpbk_pkg.sv
package feac_lpbk_pkg;

  localparam int CODE_W = 6;

  localparam logic [CODE_W-1:0] CODE_ACT   = 6'b000111;
  localparam logic [CODE_W-1:0] CODE_DEACT = 6'b011100;
  localparam logic [CODE_W-1:0] CODE_ALL   = 6'b010011;
  localparam logic [CODE_W-1:0] CODE_DS3   = 6'b011011;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_ACT   = 2'd1,
    CMD_DEACT = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_ACT   = 3'd1,
    K_DEACT = 3'd2,
    K_ALL   = 3'd3,
    K_DS3   = 3'd4,
    K_CHAN  = 3'd5
  } kind_e;

endpackage

// File: rtl/feac_code_classify.sv
module feac_code_classify
  import feac_lpbk_pkg::*;
#(
  parameter int NUM_DS1   = 28,
  parameter int CHAN_BASE = 33,
  localparam int IDX_W    = $clog2(NUM_DS1)
) (
  input  logic [CODE_W-1:0] code_i,
  output kind_e             kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int CHAN_LAST = CHAN_BASE + NUM_DS1 - 1;

  logic [CODE_W-1:0] offs;

  always_comb begin
    offs = code_i - CODE_W'(CHAN_BASE);
    idx_o = offs[IDX_W-1:0];
    if (code_i == CODE_ACT)
      kind_o = K_ACT;
    else if (code_i == CODE_DEACT)
      kind_o = K_DEACT;
    else if (code_i == CODE_ALL)
      kind_o = K_ALL;
    else if (code_i == CODE_DS3)
      kind_o = K_DS3;
    else if ((int'(code_i) >= CHAN_BASE) && (int'(code_i) <= CHAN_LAST))
      kind_o = K_CHAN;
    else
      kind_o = K_OTHER;
  end

endmodule

// File: rtl/feac_cmd_track.sv
module feac_cmd_track
  import feac_lpbk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vld_i,
  input  kind_e kind_i,
  output cmd_e  cmd_o
);

  cmd_e cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_NONE;
    end else if (vld_i) begin
      case (kind_i)
        K_ACT:                  cmd_q <= CMD_ACT;
        K_DEACT:                cmd_q <= CMD_DEACT;
        K_ALL, K_DS3, K_CHAN:   cmd_q <= CMD_NONE;
        default:                cmd_q <= cmd_q;
      endcase
    end
  end

  assign cmd_o = cmd_q;

  // R7: an indication always leaves no pending command
  a_r7_cmd_dropped: assert property (@(posedge clk) disable iff (rst)
    vld_i && (kind_i == K_ALL || kind_i == K_DS3 || kind_i == K_CHAN)
      |=> cmd_q == CMD_NONE);

  // R8: a foreign codeword keeps the pending command
  a_r8_cmd_kept: assert property (@(posedge clk) disable iff (rst)
    (!vld_i || kind_i == K_OTHER) |=> $stable(cmd_q));

endmodule

// File: rtl/feac_lb_status.sv
module feac_lb_status
  import feac_lpbk_pkg::*;
#(
  parameter int NUM_DS1  = 28,
  localparam int IDX_W   = $clog2(NUM_DS1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_i,
  input  kind_e              kind_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  cmd_e               cmd_i,
  output logic               ds3_lb_o,
  output logic [NUM_DS1-1:0] ds1_lb_o
);

  logic apply;
  logic set_val;

  assign apply   = vld_i && (cmd_i != CMD_NONE);
  assign set_val = (cmd_i == CMD_ACT);

  always_ff @(posedge clk) begin
    if (rst)
      ds3_lb_o <= 1'b0;
    else if (apply && kind_i == K_DS3)
      ds3_lb_o <= set_val;
  end

  for (genvar i = 0; i < NUM_DS1; i++) begin : g_ds1
    always_ff @(posedge clk) begin
      if (rst)
        ds1_lb_o[i] <= 1'b0;
      else if (apply && (kind_i == K_ALL ||
                         (kind_i == K_CHAN && idx_i == IDX_W'(i))))
        ds1_lb_o[i] <= set_val;
    end
  end

  // R6: a single-channel code moves at most one DS1 bit
  a_r6_one_bit: assert property (@(posedge clk) disable iff (rst)
    vld_i && kind_i == K_CHAN |=> $countones(ds1_lb_o ^ $past(ds1_lb_o)) <= 1);

  // R7: without a pending command nothing moves
  a_r7_no_cmd_inert: assert property (@(posedge clk) disable iff (rst)
    cmd_i == CMD_NONE |=> $stable(ds1_lb_o) && $stable(ds3_lb_o));

endmodule

// File: rtl/feac_code_irq_reg.sv
module feac_code_irq_reg
  import feac_lpbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  kind_e             kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              irq_clr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);

  logic hit;
  assign hit = vld_i && (kind_i != K_OTHER);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (hit)
        code_o <= code_i;
      if (hit)
        irq_o <= 1'b1;
      else if (irq_clr_i)
        irq_o <= 1'b0;
    end
  end

  // R2: the interrupt stays up until a clear
  a_r2_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    irq_o && !irq_clr_i |=> irq_o);

endmodule

// File: rtl/feac_lpbk_decoder.sv
module feac_lpbk_decoder
  import feac_lpbk_pkg::*;
#(
  parameter int NUM_DS1   = 28,
  parameter int CHAN_BASE = 33
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [5:0]         code_i,
  input  logic               code_vld_i,
  input  logic               irq_clr_i,
  output logic [5:0]         code_o,
  output logic               irq_o,
  output logic               ds3_lb_o,
  output logic [NUM_DS1-1:0] ds1_lb_o
);

  localparam int IDX_W = $clog2(NUM_DS1);

  kind_e            kind;
  logic [IDX_W-1:0] idx;
  cmd_e             cmd;

  feac_code_classify #(.NUM_DS1(NUM_DS1), .CHAN_BASE(CHAN_BASE)) u_class (
    .code_i (code_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  feac_cmd_track u_cmd (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (code_vld_i),
    .kind_i (kind),
    .cmd_o  (cmd)
  );

  feac_lb_status #(.NUM_DS1(NUM_DS1)) u_lb (
    .clk      (clk),
    .rst      (rst),
    .vld_i    (code_vld_i),
    .kind_i   (kind),
    .idx_i    (idx),
    .cmd_i    (cmd),
    .ds3_lb_o (ds3_lb_o),
    .ds1_lb_o (ds1_lb_o)
  );

  feac_code_irq_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (code_vld_i),
    .kind_i    (kind),
    .code_i    (code_i),
    .irq_clr_i (irq_clr_i),
    .code_o    (code_o),
    .irq_o     (irq_o)
  );

  // R1: a recognised codeword is latched
  a_r1_code_load: assert property (@(posedge clk) disable iff (rst)
    code_vld_i && kind != K_OTHER |=> code_o == $past(code_i));

  // R2: a recognised codeword raises the interrupt
  a_r2_irq_set: assert property (@(posedge clk) disable iff (rst)
    code_vld_i && kind != K_OTHER |=> irq_o);

  // R8: a foreign codeword touches no output state
  a_r8_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
    code_vld_i && kind == K_OTHER
      |=> $stable(code_o) && $stable(ds1_lb_o) && $stable(ds3_lb_o));

  // R4: a pending activate followed by the DS3 indication sets the DS3 bit
  a_r4_ds3_set: assert property (@(posedge clk) disable iff (rst)
    code_vld_i && kind == K_DS3 && cmd == CMD_ACT |=> ds3_lb_o);

  // R3: loopback bits are still on idle cycles
  a_r3_idle_still: assert property (@(posedge clk) disable iff (rst)
    !code_vld_i |=> $stable(ds1_lb_o) && $stable(ds3_lb_o) && $stable(code_o));

endmodule

// File: tb/feac_lpbk_decoder_tb_top.sv
module feac_lpbk_decoder_tb_top;

  localparam logic [5:0] C_ACT   = 6'b000111;
  localparam logic [5:0] C_DEACT = 6'b011100;
  localparam logic [5:0] C_ALL   = 6'b010011;
  localparam logic [5:0] C_DS3   = 6'b011011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  code_i = '0;
  logic        code_vld_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic [5:0]  code_o;
  logic        irq_o;
  logic        ds3_lb_o;
  logic [27:0] ds1_lb_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  feac_lpbk_decoder dut_i (
    .clk        (clk),
    .rst        (rst),
    .code_i     (code_i),
    .code_vld_i (code_vld_i),
    .irq_clr_i  (irq_clr_i),
    .code_o     (code_o),
    .irq_o      (irq_o),
    .ds3_lb_o   (ds3_lb_o),
    .ds1_lb_o   (ds1_lb_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive for one cycle from a falling edge; results visible at the next falling edge
  task automatic send(input logic [5:0] c, input logic clr = 1'b0);
    @(negedge clk);
    code_i = c;
    code_vld_i = 1'b1;
    irq_clr_i = clr;
    @(negedge clk);
    code_vld_i = 1'b0;
    irq_clr_i = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 code", 64'(code_o), 64'h0);
    check("R9 irq", 64'(irq_o), 64'h0);
    check("R9 ds3", 64'(ds3_lb_o), 64'h0);
    check("R9 ds1", 64'(ds1_lb_o), 64'h0);
  endtask

  task automatic t_ds3();
    send(C_ACT);
    check("R3 command alone", 64'(ds3_lb_o), 64'h0);
    check("R1 code act", 64'(code_o), 64'(C_ACT));
    check("R2 irq set", 64'(irq_o), 64'h1);
    send(C_DS3);
    check("R4 ds3 set", 64'(ds3_lb_o), 64'h1);
    check("R1 code ds3", 64'(code_o), 64'(C_DS3));
    send(C_DEACT);
    send(C_DS3);
    check("R4 ds3 cleared", 64'(ds3_lb_o), 64'h0);
  endtask

  task automatic t_all_ds1();
    send(C_ACT);
    send(C_ALL);
    check("R5 all set", 64'(ds1_lb_o), 64'hFFF_FFFF);
    check("R5 ds3 untouched", 64'(ds3_lb_o), 64'h0);
    send(C_DEACT);
    send(C_ALL);
    check("R5 all cleared", 64'(ds1_lb_o), 64'h0);
  endtask

  task automatic t_single();
    send(C_ACT);
    send(6'b100001);
    check("R6 first channel", 64'(ds1_lb_o), 64'h1);
    send(C_ACT);
    send(6'b111100);
    check("R6 last channel", 64'(ds1_lb_o), 64'h800_0001);
    send(C_ACT);
    send(6'd40);
    check("R6 mid channel", 64'(ds1_lb_o), 64'h800_0081);
    send(C_DEACT);
    send(6'b100001);
    check("R6 channel cleared", 64'(ds1_lb_o), 64'h800_0080);
  endtask

  task automatic t_no_cmd();
    send(6'd41);
    check("R7 no pending cmd", 64'(ds1_lb_o), 64'h800_0080);
    check("R7 code updated", 64'(code_o), 64'd41);
    send(C_DS3);
    check("R7 ds3 no pending", 64'(ds3_lb_o), 64'h0);
  endtask

  task automatic t_replace();
    send(C_DEACT);
    send(C_ACT);
    send(6'd34);
    check("R3 replaced by act", 64'(ds1_lb_o), 64'h800_0082);
    send(C_ACT);
    send(C_DEACT);
    send(6'd40);
    check("R3 replaced by deact", 64'(ds1_lb_o), 64'h800_0002);
  endtask

  task automatic t_foreign();
    clear_irq();
    check("R2 irq cleared", 64'(irq_o), 64'h0);
    send(6'b000000);
    check("R8 code kept", 64'(code_o), 64'd40);
    check("R8 irq kept", 64'(irq_o), 64'h0);
    send(C_ACT);
    send(6'b100000);
    send(6'b111101);
    check("R8 code kept2", 64'(code_o), 64'(C_ACT));
    send(C_DS3);
    check("R8 cmd kept", 64'(ds3_lb_o), 64'h1);
    check("R8 ds1 kept", 64'(ds1_lb_o), 64'h800_0002);
  endtask

  task automatic t_irq_race();
    clear_irq();
    send(C_ALL, 1'b1);
    check("R2 set wins over clear", 64'(irq_o), 64'h1);
    repeat (3) @(negedge clk);
    check("R2 irq sticky", 64'(irq_o), 64'h1);
    clear_irq();
    check("R2 irq cleared again", 64'(irq_o), 64'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ds3();
        t_all_ds1();
        t_single();
        t_no_cmd();
        t_replace();
        t_foreign();
        t_irq_race();
        t_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule